// File: doc/BRIEF.md
# Decimal Digit Adder with Gate-Level Correction

This block adds two binary-coded decimal digits and an incoming decimal carry, and returns one decimal result digit and an outgoing decimal carry. It is purely combinational. A single four-bit binary ripple addition forms the raw sum first.

The decimal adjustment that follows never needs a general adder. The amount to add is only ever zero or six. A small network therefore detects when the raw value passes nine and flips the upper three sum bits directly with XOR, AND and OR gates. The same detect signal is the decimal carry-out.

The block serves as the digit slice of wider decimal datapaths. Each operand is expected to hold a code from 0 to 9. Codes 10 to 15 fall outside the behaviour defined here.

Top module: `bcd_digit_add`

## Requirements
- R1: For operands 0 to 9 and any carry-in, `sum_o` equals (a + b + cin) mod 10, encoded as plain 4-bit binary 0000 to 1001.
- R2: `cout_o` is 1 exactly when a + b + cin is 10 or more, and 0 otherwise.
- R3: For valid operands, `sum_o` is always a legal decimal code, never above 1001.
- R4: When a + b + cin is 9 or less, `sum_o` equals the raw binary total unchanged.
- R5: When a + b + cin lies between 10 and 19, `sum_o` equals the raw total minus ten, which is the low four bits of the raw total plus six.
- R6: Bit 0 of `sum_o` always equals a[0] XOR b[0] XOR cin; the correction never alters it.
- R7: The boundary cases give these results: 0+0+0 gives digit 0 with carry 0, 9+0+1 gives digit 0 with carry 1, 9+9+0 gives digit 8 with carry 1, and 9+9+1 gives digit 9 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First decimal operand digit, 0 to 9 |
| b_i | input | 4 | Second decimal operand digit, 0 to 9 |
| cin_i | input | 1 | Incoming decimal carry |
| sum_o | output | 4 | Decimal result digit |
| cout_o | output | 1 | Outgoing decimal carry |

## Verification
The bench builds the block with its default digit width of four bits, the only width at which the correction equations apply. At that width the operand space of valid digits is small. This lets the bench sweep every one of the 200 combinations of two digits and a carry-in. The sweep covers both sides of the nine-to-ten threshold for every raw total from 0 to 19, including the largest total, 19, where the binary adder itself carries out.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  // width of one decimal digit code
  localparam int unsigned DIGIT_W = 4;
  // largest legal digit value
  localparam int unsigned DIGIT_MAX = 9;
  // decimal adjustment constant folded into the sum
  localparam logic [DIGIT_W-1:0] ADJ = 4'd6;

  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_full_add_bit.sv
module bcd_full_add_bit (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic hs;

  always_comb begin
    hs   = x_i ^ y_i;
    s_o  = hs ^ ci_i;
    co_o = (x_i & y_i) | (hs & ci_i);
  end
endmodule

// File: rtl/bcd_bin_ripple.sv
module bcd_bin_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  localparam int unsigned NC = W + 1;

  logic [NC-1:0] chain;

  assign chain[0] = ci_i;

  for (genvar k = 0; k < W; k++) begin : g_cell
    bcd_full_add_bit u_fa (
      .x_i  (x_i[k]),
      .y_i  (y_i[k]),
      .ci_i (chain[k]),
      .s_o  (s_o[k]),
      .co_o (chain[k+1])
    );
  end

  assign co_o = chain[NC-1];
endmodule

// File: rtl/bcd_fix_detect.sv
module bcd_fix_detect
  import bcd_digit_pkg::*;
(
  input  digit_t raw_i,
  input  logic   rc_i,
  output logic   fix_o
);
  // raw value above nine: binary carry, or 11xx, or 1x1x
  always_comb begin
    fix_o = rc_i | (raw_i[3] & raw_i[2]) | (raw_i[3] & raw_i[1]);
  end
endmodule

// File: rtl/bcd_fix_apply.sv
module bcd_fix_apply
  import bcd_digit_pkg::*;
(
  input  digit_t raw_i,
  input  logic   fix_i,
  output digit_t dig_o
);
  logic t2;
  logic t3;

  always_comb begin
    t2       = fix_i & ~raw_i[1];
    t3       = fix_i & (raw_i[1] | raw_i[2]);
    dig_o[0] = raw_i[0];
    dig_o[1] = raw_i[1] ^ fix_i;
    dig_o[2] = raw_i[2] ^ t2;
    dig_o[3] = raw_i[3] ^ t3;
  end
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_digit_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  output logic [3:0] sum_o,
  output logic       cout_o
);
  localparam int unsigned TW = DIGIT_W + 1;

  digit_t raw;
  logic   raw_c;
  logic   fix;

  bcd_bin_ripple #(.W(DIGIT_W)) u_add (
    .x_i  (a_i),
    .y_i  (b_i),
    .ci_i (cin_i),
    .s_o  (raw),
    .co_o (raw_c)
  );

  bcd_fix_detect u_det (
    .raw_i (raw),
    .rc_i  (raw_c),
    .fix_o (fix)
  );

  bcd_fix_apply u_fix (
    .raw_i (raw),
    .fix_i (fix),
    .dig_o (sum_o)
  );

  assign cout_o = fix;

  // checks on settled combinational values, valid operands only
  logic [TW-1:0] tot;
  logic          ops_ok;

  always_comb begin
    tot    = TW'(a_i) + TW'(b_i) + TW'(cin_i);
    ops_ok = (a_i <= 4'(DIGIT_MAX)) && (b_i <= 4'(DIGIT_MAX));
    if (ops_ok) begin
      p_digit_legal_r3: assert (sum_o <= 4'(DIGIT_MAX))
        else $error("R3: digit out of range");
      p_carry_thresh_r2: assert (cout_o == (tot > TW'(DIGIT_MAX)))
        else $error("R2: carry mismatch");
      p_digit_mod_r1: assert (sum_o == 4'(tot % 10))
        else $error("R1: digit mismatch");
      if (tot <= TW'(DIGIT_MAX)) begin
        p_no_adjust_r4: assert (sum_o == tot[3:0])
          else $error("R4: unadjusted digit changed");
      end else begin
        p_adjust_six_r5: assert (sum_o == 4'(tot[3:0] + ADJ))
          else $error("R5: adjusted digit wrong");
      end
    end
    p_lsb_kept_r6: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
      else $error("R6: lsb altered");
  end
endmodule

// File: tb/sim_bcd_digit_add.sv
module sim_bcd_digit_add;
  localparam time CLK_PER = 10ns;
  localparam int  WDOG_CYC = 5000;

  typedef struct {
    int  ta;
    int  tb;
    int  tc;
    bit  edge_case;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic [3:0] a;
  logic [3:0] b;
  logic       cin;
  logic [3:0] sum;
  logic       cout;

  int    n_chk;
  int    n_err;
  bit    drv_done;
  item_t sb_q[$];

  bcd_digit_add u0 (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int x, input int y, input int c, input bit e);
    item_t it;
    @(posedge clk);
    a   <= 4'(x);
    b   <= 4'(y);
    cin <= c[0];
    it.ta = x; it.tb = y; it.tc = c; it.edge_case = e;
    sb_q.push_back(it);
  endtask

  // monitor: compare at the falling edge after each drive
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      int t, ed, ec;
      it = sb_q.pop_front();
      t  = it.ta + it.tb + it.tc;
      ed = t % 10;
      ec = (t >= 10) ? 1 : 0;
      check(int'(sum) == ed, "R1 digit", int'(sum), ed);
      check(int'(cout) == ec, "R2 carry", int'(cout), ec);
      check(int'(sum) <= 9, "R3 legal code", int'(sum), 9);
      if (t <= 9) check(int'(sum) == t, "R4 no adjust", int'(sum), t);
      else        check(int'(sum) == t - 10, "R5 adjust", int'(sum), t - 10);
      check(int'(sum[0]) == ((it.ta ^ it.tb ^ it.tc) & 1), "R6 lsb",
            int'(sum[0]), (it.ta ^ it.tb ^ it.tc) & 1);
      if (it.edge_case) begin
        check(int'(sum) == ed && int'(cout) == ec, "R7 boundary",
              int'(cout) * 10 + int'(sum), ec * 10 + ed);
      end
    end
  end

  initial begin
    n_chk = 0; n_err = 0; drv_done = 1'b0;
    rst_n = 1'b0; a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sum == 4'd0 && cout == 1'b0, "R1 reset idle zero",
          int'(cout) * 10 + int'(sum), 0);
    rst_n = 1'b1;
    // boundary cases first (R7)
    drive(0, 0, 0, 1'b1);
    drive(9, 0, 1, 1'b1);
    drive(9, 9, 0, 1'b1);
    drive(9, 9, 1, 1'b1);
    // full sweep of valid digits and carry-in
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 10; x++)
        for (int y = 0; y < 10; y++)
          drive(x, y, c, 1'b0);
    @(posedge clk);
    @(negedge clk);
    #1;
    drv_done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!drv_done && cyc < WDOG_CYC) begin
      @(posedge clk);
      cyc++;
    end
    if (!drv_done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_CYC);
    end
    if (sb_q.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 pending items actual=%0d expected=%0d", sb_q.size(), 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule